// File: doc/BRIEF.md
# Block-Lookahead Binary Adder

This block adds two unsigned words and a carry-in in a single combinational pass. With the default settings it returns a 32-bit sum and a carry-out. The operand is divided into 4-bit groups. Every bit column first forms a carry-generate term and a carry-propagate term. Each group then reduces its four pairs of terms to one group generate and one group propagate.

The carry that enters a group leaves it through one AND/OR stage built on those group terms, so it never passes through the group's internal chain. The group carries are chained from the least significant group upward. Inside each group, the sum bits come from rippling the group's carry-in through four full-adder stages.

The block has no clock and no state, and its outputs follow its inputs. It can sit directly in a datapath as a wide adder. Both the word width and the group width are parameters, and the word width must be a multiple of the group width.

Top module: `cla_adder32`

## Requirements
- R1: `sum` equals the low WIDTH bits of `a + b + cin`, with all three taken as unsigned values.
- R2: `cout` equals bit WIDTH of `a + b + cin`, which is the carry leaving the most significant group.
- R3: A column where both operand bits are 1 generates a carry into the next column whatever its incoming carry. A column where exactly one operand bit is 1 passes its incoming carry on. A column where both operand bits are 0 stops the carry.
- R4: When a group generates a carry internally, its carry-out is 1 whatever carry enters that group.
- R5: When every column of a group propagates and none generates, the group's carry-out equals its carry-in. An all-ones operand plus zero with `cin` = 1 therefore carries through every group to `cout`.
- R6: The carry into group k+1 is the carry-out of group k. Group 0 takes `cin`, and the chain runs from the lowest group upward.
- R7: Corner operands give the arithmetic result: zero plus zero, all ones plus one, and alternating bit patterns added with carry-in 0 and 1.
- R8: The block is combinational. A change on `a`, `b` or `cin` appears on `sum` and `cout` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH (32) | First unsigned operand |
| b | input | WIDTH (32) | Second unsigned operand |
| cin | input | 1 | Carry into the least significant column |
| sum | output | WIDTH (32) | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant group |

## Verification
The hardest condition to reach from the ports is a carry that must cross many groups purely by propagation: a group carry-out that depends only on its carry-in. Random operands almost never make all four columns of several neighbouring groups propagate at once. The stimulus therefore builds such operands on purpose. It uses all-ones plus a low carry, alternating patterns that are complementary or equal, and a generate placed at the top of one group so that its carry crosses into the next. A walking generate bit visits every column, including the top column, where the carry lands on `cout`.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_WIDTH = 32;
  localparam int DEF_BLK   = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } grp_term_t;
endpackage

// File: rtl/cla_col_pg.sv
module cla_col_pg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] prop
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    assign gen[i]  = a[i] & b[i];
    assign prop[i] = a[i] | b[i];
  end
endmodule

// File: rtl/cla_grp_reduce.sv
module cla_grp_reduce
  import cla_pkg::*;
#(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] gen,
  input  logic [BLK-1:0] prop,
  output grp_term_t      grp
);
  always_comb begin
    grp.gen  = gen[0];
    grp.prop = prop[0];
    for (int i = 1; i < BLK; i++) begin
      grp.gen  = gen[i] | (prop[i] & grp.gen);
      grp.prop = grp.prop & prop[i];
    end
  end
endmodule

// File: rtl/cla_grp_sum.sv
module cla_grp_sum #(
  parameter int BLK = 4
) (
  input  logic [BLK-1:0] a,
  input  logic [BLK-1:0] b,
  input  logic [BLK-1:0] gen,
  input  logic [BLK-1:0] prop,
  input  logic           cy_in,
  output logic [BLK-1:0] sum
);
  logic [BLK-1:0] rip;

  assign rip[0] = cy_in;
  for (genvar i = 0; i < BLK; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ rip[i];
    if (i < BLK - 1) begin : g_rip
      assign rip[i+1] = gen[i] | (prop[i] & rip[i]);
    end
  end
endmodule

// File: rtl/cla_adder32.sv
module cla_adder32
  import cla_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH,
  parameter int BLK   = DEF_BLK
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NBLK = WIDTH / BLK;

  logic [WIDTH-1:0] col_g;
  logic [WIDTH-1:0] col_p;
  logic [NBLK:0]    blk_cy;
  logic [NBLK-1:0]  grp_g;
  logic [NBLK-1:0]  grp_p;

  cla_col_pg #(.WIDTH(WIDTH)) u_pg (
    .a    (a),
    .b    (b),
    .gen  (col_g),
    .prop (col_p)
  );

  assign blk_cy[0] = cin;

  for (genvar k = 0; k < NBLK; k++) begin : g_grp
    grp_term_t term;

    cla_grp_reduce #(.BLK(BLK)) u_red (
      .gen  (col_g[k*BLK +: BLK]),
      .prop (col_p[k*BLK +: BLK]),
      .grp  (term)
    );

    assign grp_g[k]    = term.gen;
    assign grp_p[k]    = term.prop;
    assign blk_cy[k+1] = term.gen | (term.prop & blk_cy[k]);

    cla_grp_sum #(.BLK(BLK)) u_sum (
      .a     (a[k*BLK +: BLK]),
      .b     (b[k*BLK +: BLK]),
      .gen   (col_g[k*BLK +: BLK]),
      .prop  (col_p[k*BLK +: BLK]),
      .cy_in (blk_cy[k]),
      .sum   (sum[k*BLK +: BLK])
    );
  end

  assign cout = blk_cy[NBLK];
endmodule

// File: rtl/cla_adder32_chk.sv
module cla_adder32_chk #(
  parameter int WIDTH = 32,
  parameter int BLK   = 4
) (
  input logic [WIDTH-1:0]      a,
  input logic [WIDTH-1:0]      b,
  input logic                  cin,
  input logic [WIDTH-1:0]      sum,
  input logic                  cout,
  input logic [WIDTH/BLK:0]    blk_cy,
  input logic [WIDTH/BLK-1:0]  grp_g,
  input logic [WIDTH/BLK-1:0]  grp_p
);
  localparam int NBLK = WIDTH / BLK;

  logic [WIDTH:0] total;
  logic           known;

  assign total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  assign known = !$isunknown({a, b, cin});

  always_comb begin
    if (known) begin
      // R1
      sum_match_chk: assert (sum == total[WIDTH-1:0]);
      // R2
      cout_match_chk: assert (cout == total[WIDTH]);
      // R6
      chain_base_chk: assert (blk_cy[0] == cin);
    end
  end

  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    localparam int HI = (k + 1) * BLK;
    logic [HI:0] part;
    assign part = {1'b0, a[HI-1:0]} + {1'b0, b[HI-1:0]} + {{HI{1'b0}}, cin};

    always_comb begin
      if (known) begin
        // R6
        grp_carry_chk: assert (blk_cy[k+1] == part[HI]);
        // R4
        grp_gen_chk: assert (!grp_g[k] || blk_cy[k+1]);
        // R5
        grp_pass_chk: assert (!(grp_p[k] && !grp_g[k]) || (blk_cy[k+1] == blk_cy[k]));
      end
    end
  end
endmodule

bind cla_adder32 cla_adder32_chk #(.WIDTH(WIDTH), .BLK(BLK)) u_chk (
  .a      (a),
  .b      (b),
  .cin    (cin),
  .sum    (sum),
  .cout   (cout),
  .blk_cy (blk_cy),
  .grp_g  (grp_g),
  .grp_p  (grp_p)
);

// File: tb/cla_adder32_tb.sv
module cla_adder32_tb;
  localparam int W = 32;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W-1:0] s;
    logic         co;
    logic [7:0]   req;
  } vec_t;

  // Entry tags: R7 zero, R7 ones+1, R5 pass, R7 alt, R7 alt+cin, R1, R1,
  // R6 group hop, R6 bytes, R3 generate, R2 top, R2 no top, R4 group gen, R1.
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0, 8'd7},
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 8'd7},
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1, 8'd5},
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0, 8'd7},
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1, 8'd7},
    '{32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 32'h5555_5554, 1'b1, 8'd1},
    '{32'h5555_5555, 32'h5555_5555, 1'b1, 32'hAAAA_AAAB, 1'b0, 8'd1},
    '{32'h0000_000F, 32'h0000_0001, 1'b0, 32'h0000_0010, 1'b0, 8'd6},
    '{32'h0F0F_0F0F, 32'h0101_0101, 1'b0, 32'h1010_1010, 1'b0, 8'd6},
    '{32'h0000_0008, 32'h0000_0008, 1'b0, 32'h0000_0010, 1'b0, 8'd3},
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 8'd2},
    '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0, 8'd2},
    '{32'h0000_00F0, 32'h0000_0010, 1'b1, 32'h0000_0101, 1'b0, 8'd4},
    '{32'h1234_5678, 32'h8765_4321, 1'b0, 32'h9999_9999, 1'b0, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic cin = 1'b0;
  logic [W-1:0] sum;
  logic cout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cla_adder32 u_dut (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  task automatic check(input string tag, input logic [W-1:0] es, input logic ec);
    n_cmp++;
    if (sum !== es || cout !== ec) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h cin=%0b got sum=%h cout=%0b expected sum=%h cout=%0b",
               tag, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
    @(negedge clk);
    a = va;
    b = vb;
    cin = vc;
    #2;
  endtask

  initial begin
    logic [W:0] ref_v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: idle inputs give zero outputs (R7)
    #3;
    check("R7 idle", '0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].ci);
      check($sformatf("R%0d table[%0d]", VECS[i].req, i), VECS[i].s, VECS[i].co);
    end

    // R3: walking generate column
    for (int k = 0; k < W; k++) begin
      apply(W'(1) << k, W'(1) << k, 1'b0);
      check($sformatf("R3 gen col %0d", k), (k == W-1) ? '0 : (W'(1) << (k+1)), k == W-1);
    end

    // R4: group generate ignores its carry-in
    apply(32'h0000_0F00, 32'h0000_0100, 1'b0);
    check("R4 gen cin0", 32'h0000_1000, 1'b0);
    apply(32'h0000_0F00, 32'h0000_0100, 1'b1);
    check("R4 gen cin1", 32'h0000_1001, 1'b0);

    // R5: propagate-only group passes its carry-in
    apply(32'h0000_00F0, 32'h0000_0000, 1'b0);
    check("R5 pass cin0", 32'h0000_00F0, 1'b0);
    apply(32'h0000_00FF, 32'h0000_0000, 1'b1);
    check("R5 pass cin1", 32'h0000_0100, 1'b0);

    // R6: carry hops each group boundary, lowest first
    for (int g = 1; g < W/4; g++) begin
      logic [W-1:0] low;
      low = (W'(1) << (4*g)) - 1;
      apply(low, 32'h0000_0001, 1'b0);
      check($sformatf("R6 hop %0d", g), W'(1) << (4*g), 1'b0);
    end

    // R8: change inputs mid-cycle, sample before any edge
    @(posedge clk);
    #3;
    a = 32'h0000_FFFF;
    b = 32'h0000_0001;
    cin = 1'b0;
    #1;
    check("R8 no clock", 32'h0001_0000, 1'b0);

    // R1 and R2: random operands against a behavioural sum
    for (int i = 0; i < 2000; i++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic rc;
      ra = $urandom;
      rb = $urandom;
      rc = 1'($urandom);
      apply(ra, rb, rc);
      ref_v = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      check("R1/R2 random", ref_v[W-1:0], ref_v[W]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule